// File: doc/BRIEF.md
# Debug Memory Word Streamer

This block lets a debugger watch four chosen words of an internal data memory at the full processing rate. The words are sent out over a single serial pin. Each of four address slots names one memory location. A pass-start strobe marks the beginning of each processing pass. When that strobe arrives and monitoring is enabled, the block reads the four locations through a one-cycle-latency read port and copies them into a private shadow buffer. It then shifts the four words out back to back on the serial pin, in slot order. The block runs entirely on the test clock that paces the serial line.

Each word goes out as a 35-cycle frame: a leading flag bit of 1, then the 32 data bits with the most significant bit first, then two low guard bits. When no frame is being sent, the line is held low. This lets an external capture tool find each word by its flag bit.

The controller is a three-state machine. In IDLE the line is low and no reads are issued. The transition IDLE→FETCH (start) fires on a pass-start strobe while the enable is high. In FETCH the four reads are issued and their data captured. The transition FETCH→SEND (captured) fires once the last read data is in the shadow buffer. In SEND the frames are shifted. SEND→SEND (next word) moves to the following slot at the end of a frame. SEND→IDLE (done) fires at the end of a frame when that frame held the last slot or the enable has been cleared.

Top module: `dbg_word_streamer`

## Requirements
- R1: After reset, and whenever no frame is in progress, `sdo_o` is 0 and `rd_req_o` is 0.
- R2: A pass-start strobe sampled in IDLE with `enable_i` high produces exactly four reads, one per cycle, for slots 0, 1, 2, 3 in that order. Slot k's address is `sel_addr_i[8k+7:8k]`. `rd_data_i` is taken one cycle after each request.
- R3: Each frame lasts 35 cycles: one flag cycle with `sdo_o` = 1, then 32 data cycles from bit 31 down to bit 0, then two cycles with `sdo_o` = 0.
- R4: Call the clock edge that samples the accepted strobe edge 0. The flag of slot 0 is driven in the cycle after edge 5. The frames for slots 1, 2 and 3 follow with no gap between them.
- R5: Frames carry the memory contents as captured during FETCH. Memory writes made after FETCH do not change the bits shifted out.
- R6: A pass-start strobe that arrives during FETCH or SEND is ignored: it causes no reads and no extra frames.
- R7: While `enable_i` is low, a pass-start strobe in IDLE is ignored: no reads are issued and the line stays low.
- R8: If `enable_i` falls during SEND, the frame in progress finishes in full. The line then stays low and no later slots are sent.
- R9: A strobe sampled in the first cycle after SEND→IDLE starts a new burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tclk_i | input | 1 | Test clock; paces all logic and the serial line |
| rst_ni | input | 1 | Active-low reset, synchronous to `tclk_i` |
| enable_i | input | 1 | Monitoring enable |
| pass_start_i | input | 1 | One-cycle strobe at the beginning of a processing pass |
| sel_addr_i | input | 32 | Four 8-bit address slots; slot k occupies bits 8k+7..8k |
| rd_req_o | output | 1 | Memory read request |
| rd_addr_o | output | 8 | Memory read address |
| rd_data_i | input | 32 | Read data, valid the cycle after a request |
| sdo_o | output | 1 | Serial data output, low when idle |

## Verification
The assertions assume that `rd_data_i` is valid exactly one cycle after `rd_req_o`. They also assume that `sel_addr_i` stays stable from the strobe until FETCH ends. The bench keeps to both. Its memory model answers each request with a registered read. It changes the address slots only in the same cycle as the strobe, and writes to memory only after the fetch window has closed. Strobes are always single-cycle pulses driven on the falling edge, so each one is seen at exactly one rising edge. That lets the bench place each ignored strobe deliberately inside FETCH or inside SEND.

// File: rtl/dws_pkg.sv
package dws_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SEND  = 2'd2
    } dws_state_e;

endpackage

// File: rtl/dws_ctrl.sv
module dws_ctrl
    import dws_pkg::*;
#(
    parameter int NWORDS    = 4,
    parameter int FRAME_LEN = 35
) (
    input  logic                              clk_i,
    input  logic                              rst_ni,
    input  logic                              pass_start_i,
    input  logic                              enable_i,
    output dws_state_e                        state_o,
    output logic [$clog2(NWORDS+1)-1:0]       fetch_cnt_o,
    output logic [$clog2(NWORDS)-1:0]         word_idx_o,
    output logic [$clog2(FRAME_LEN)-1:0]      bit_idx_o
);

    localparam int FCW = $clog2(NWORDS + 1);
    localparam int WIW = $clog2(NWORDS);
    localparam int BIW = $clog2(FRAME_LEN);

    dws_state_e       state_q, state_d;
    logic [FCW-1:0]   fcnt_q;
    logic [WIW-1:0]   widx_q;
    logic [BIW-1:0]   bidx_q;
    logic             frame_end;
    logic             last_word;
    logic             fetch_done;

    assign frame_end  = (bidx_q == BIW'(FRAME_LEN - 1));
    assign last_word  = (widx_q == WIW'(NWORDS - 1));
    assign fetch_done = (fcnt_q == FCW'(NWORDS));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (pass_start_i && enable_i)         state_d = ST_FETCH; // start
            ST_FETCH: if (fetch_done)                       state_d = ST_SEND;  // captured
            ST_SEND:  if (frame_end && (last_word || !enable_i))
                                                            state_d = ST_IDLE;  // done
            default:                                        state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // counters
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fcnt_q <= '0;
            widx_q <= '0;
            bidx_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    fcnt_q <= '0;
                    widx_q <= '0;
                    bidx_q <= '0;
                end
                ST_FETCH: begin
                    fcnt_q <= fetch_done ? '0 : fcnt_q + 1'b1;
                    widx_q <= '0;
                    bidx_q <= '0;
                end
                ST_SEND: begin
                    if (frame_end) begin
                        bidx_q <= '0;
                        widx_q <= widx_q + 1'b1; // next word
                    end else begin
                        bidx_q <= bidx_q + 1'b1;
                    end
                end
                default: begin
                    fcnt_q <= '0;
                    widx_q <= '0;
                    bidx_q <= '0;
                end
            endcase
        end
    end

    assign state_o     = state_q;
    assign fetch_cnt_o = fcnt_q;
    assign word_idx_o  = widx_q;
    assign bit_idx_o   = bidx_q;

    // R6: a strobe seen while sending never re-enters fetch
    a_r6_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEND) |=> (state_q != ST_FETCH));

    // R8: a frame under way is never cut short
    a_r8_frame_completes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_SEND && !frame_end) |=> (state_q == ST_SEND));

    // R7: disabled monitor stays idle
    a_r7_stay_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !enable_i) |=> (state_q == ST_IDLE));

    // R4: fetch window runs its full length
    a_r4_fetch_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FETCH && !fetch_done) |=> (state_q == ST_FETCH));

endmodule

// File: rtl/dws_fetch.sv
module dws_fetch #(
    parameter int NWORDS = 4,
    parameter int AW     = 8,
    parameter int DW     = 32
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           fetching_i,
    input  logic [$clog2(NWORDS+1)-1:0]    fetch_cnt_i,
    input  logic [NWORDS*AW-1:0]           sel_addr_i,
    input  logic [DW-1:0]                  rd_data_i,
    output logic                           rd_req_o,
    output logic [AW-1:0]                  rd_addr_o,
    output logic [NWORDS*DW-1:0]           shadow_o
);

    localparam int FCW = $clog2(NWORDS + 1);
    localparam int WIW = $clog2(NWORDS);

    logic [AW-1:0]  slot_addr [NWORDS];
    logic [WIW-1:0] slot_idx;
    logic           cap_vld_q;
    logic [WIW-1:0] cap_idx_q;
    logic           in_range;

    assign in_range = (fetch_cnt_i < FCW'(NWORDS));
    assign slot_idx = in_range ? WIW'(fetch_cnt_i) : '0;
    assign rd_req_o  = fetching_i && in_range;
    assign rd_addr_o = rd_req_o ? slot_addr[slot_idx] : '0;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cap_vld_q <= 1'b0;
            cap_idx_q <= '0;
        end else begin
            cap_vld_q <= rd_req_o;
            cap_idx_q <= slot_idx;
        end
    end

    for (genvar g = 0; g < NWORDS; g++) begin : g_slot
        assign slot_addr[g] = sel_addr_i[g*AW +: AW];

        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                shadow_o[g*DW +: DW] <= '0;
            else if (cap_vld_q && cap_idx_q == WIW'(g))
                shadow_o[g*DW +: DW] <= rd_data_i;
        end
    end

    // R2: reads are issued only inside the fetch window
    a_r2_req_only_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fetching_i |-> !rd_req_o);

    // R5: shadow buffer only changes on a returning read
    a_r5_shadow_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_vld_q |=> $stable(shadow_o));

endmodule

// File: rtl/dws_shift.sv
module dws_shift #(
    parameter int NWORDS    = 4,
    parameter int DW        = 32,
    parameter int FRAME_LEN = 35
) (
    input  logic                            clk_i,
    input  logic                            rst_ni,
    input  logic                            sending_i,
    input  logic [$clog2(NWORDS)-1:0]       word_idx_i,
    input  logic [$clog2(FRAME_LEN)-1:0]    bit_idx_i,
    input  logic [NWORDS*DW-1:0]            shadow_i,
    output logic                            sdo_o
);

    localparam int BIW = $clog2(FRAME_LEN);
    localparam int PW  = $clog2(DW);

    logic [DW-1:0] cur_word;
    logic [PW-1:0] pos;

    assign cur_word = shadow_i[word_idx_i*DW +: DW];
    assign pos      = PW'(DW - int'(bit_idx_i));

    // output process
    always_comb begin
        sdo_o = 1'b0;
        if (sending_i) begin
            if (bit_idx_i == '0)
                sdo_o = 1'b1;                      // flag
            else if (bit_idx_i <= BIW'(DW))
                sdo_o = cur_word[pos];             // data, MSB first
            else
                sdo_o = 1'b0;                      // guard bits
        end
    end

    // R1: line low outside a frame
    a_r1_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sending_i |-> !sdo_o);

    // R3: every frame opens with a high flag
    a_r3_flag_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sending_i && bit_idx_i == '0) |-> sdo_o);

    // R3: guard cycles stay low
    a_r3_tail_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sending_i && bit_idx_i > BIW'(DW)) |-> !sdo_o);

endmodule

// File: rtl/dbg_word_streamer.sv
module dbg_word_streamer
    import dws_pkg::*;
#(
    parameter int NWORDS    = 4,
    parameter int AW        = 8,
    parameter int DW        = 32,
    parameter int TAIL_BITS = 2
) (
    input  logic                   tclk_i,
    input  logic                   rst_ni,
    input  logic                   enable_i,
    input  logic                   pass_start_i,
    input  logic [NWORDS*AW-1:0]   sel_addr_i,
    output logic                   rd_req_o,
    output logic [AW-1:0]          rd_addr_o,
    input  logic [DW-1:0]          rd_data_i,
    output logic                   sdo_o
);

    localparam int FRAME_LEN = 1 + DW + TAIL_BITS;
    localparam int FCW       = $clog2(NWORDS + 1);
    localparam int WIW       = $clog2(NWORDS);
    localparam int BIW       = $clog2(FRAME_LEN);

    dws_state_e         state;
    logic [FCW-1:0]     fetch_cnt;
    logic [WIW-1:0]     word_idx;
    logic [BIW-1:0]     bit_idx;
    logic [NWORDS*DW-1:0] shadow;

    dws_ctrl #(
        .NWORDS    (NWORDS),
        .FRAME_LEN (FRAME_LEN)
    ) u_ctrl (
        .clk_i        (tclk_i),
        .rst_ni       (rst_ni),
        .pass_start_i (pass_start_i),
        .enable_i     (enable_i),
        .state_o      (state),
        .fetch_cnt_o  (fetch_cnt),
        .word_idx_o   (word_idx),
        .bit_idx_o    (bit_idx)
    );

    dws_fetch #(
        .NWORDS (NWORDS),
        .AW     (AW),
        .DW     (DW)
    ) u_fetch (
        .clk_i       (tclk_i),
        .rst_ni      (rst_ni),
        .fetching_i  (state == ST_FETCH),
        .fetch_cnt_i (fetch_cnt),
        .sel_addr_i  (sel_addr_i),
        .rd_data_i   (rd_data_i),
        .rd_req_o    (rd_req_o),
        .rd_addr_o   (rd_addr_o),
        .shadow_o    (shadow)
    );

    dws_shift #(
        .NWORDS    (NWORDS),
        .DW        (DW),
        .FRAME_LEN (FRAME_LEN)
    ) u_shift (
        .clk_i      (tclk_i),
        .rst_ni     (rst_ni),
        .sending_i  (state == ST_SEND),
        .word_idx_i (word_idx),
        .bit_idx_i  (bit_idx),
        .shadow_i   (shadow),
        .sdo_o      (sdo_o)
    );

endmodule

// File: tb/test_dbg_word_streamer.sv
`timescale 1ns/1ps
module test_dbg_word_streamer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        pass_start = 1'b0;
    logic [31:0] sel_addr = '0;
    logic        rd_req;
    logic [7:0]  rd_addr;
    logic [31:0] rd_data = '0;
    logic        sdo;

    logic [31:0] mem [256];
    bit          exp_bits[$];
    string       exp_tags[$];
    int          checks = 0;
    int          bad = 0;
    int          nreads = 0;
    bit          finished = 0;

    always #2 clk = ~clk;

    dbg_word_streamer i_dbg_word_streamer (
        .tclk_i       (clk),
        .rst_ni       (rst_n),
        .enable_i     (enable),
        .pass_start_i (pass_start),
        .sel_addr_i   (sel_addr),
        .rd_req_o     (rd_req),
        .rd_addr_o    (rd_addr),
        .rd_data_i    (rd_data),
        .sdo_o        (sdo)
    );

    // memory model: registered read
    always @(posedge clk) begin
        if (rd_req) begin
            rd_data <= mem[rd_addr];
            nreads  <= nreads + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic push_bit(input bit b, input string tag);
        exp_bits.push_back(b);
        exp_tags.push_back(tag);
    endtask

    task automatic push_word(input logic [31:0] w);
        push_bit(1'b1, "R3 flag");
        for (int i = 31; i >= 0; i--) push_bit(w[i], "R3 data");
        push_bit(1'b0, "R3 tail");
        push_bit(1'b0, "R3 tail");
    endtask

    // driver: strobe a pass, then push the expected line contents
    task automatic start_burst(input logic [7:0] a0, input logic [7:0] a1,
                               input logic [7:0] a2, input logic [7:0] a3,
                               input int nframes);
        logic [7:0] a [4];
        a[0] = a0; a[1] = a1; a[2] = a2; a[3] = a3;
        @(negedge clk);
        sel_addr   = {a3, a2, a1, a0};
        pass_start = 1'b1;
        @(posedge clk);
        #1;
        pass_start = 1'b0;
        for (int i = 0; i < 5; i++) push_bit(1'b0, "R4 fetch gap");
        for (int k = 0; k < nframes; k++) push_word(mem[a[k]]);
    endtask

    task automatic pulse_strobe();
        @(negedge clk);
        pass_start = 1'b1;
        @(negedge clk);
        pass_start = 1'b0;
    endtask

    task automatic drain();
        wait (exp_bits.size() == 0);
        repeat (3) @(negedge clk);
    endtask

    // monitor: pops one expected bit per cycle, else expects a low idle line
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (exp_bits.size() != 0) begin
                    bit    eb;
                    string et;
                    eb = exp_bits.pop_front();
                    et = exp_tags.pop_front();
                    check(sdo === eb, et, sdo, eb);
                end else begin
                    check(sdo === 1'b0, "R1 idle low", sdo, 0);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int r0;
        for (int i = 0; i < 256; i++)
            mem[i] = (32'h9E3779B9 * (i + 1)) ^ {i[7:0], 24'h5A0F3C};
        repeat (4) @(negedge clk);
        check(sdo === 1'b0, "R1 reset sdo", sdo, 0);
        check(rd_req === 1'b0, "R1 reset rd_req", rd_req, 0);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        check(rd_req === 1'b0, "R1 idle rd_req", rd_req, 0);

        // R2 R3 R4: basic burst, including top and bottom addresses
        r0 = nreads;
        start_burst(8'd3, 8'd255, 8'd0, 8'd77, 4);
        drain();
        check(nreads - r0 == 4, "R2 read count", nreads - r0, 4);

        // R9: restart in the first idle cycle after a burst
        r0 = nreads;
        start_burst(8'd10, 8'd11, 8'd12, 8'd13, 4);
        wait (exp_bits.size() == 0);
        start_burst(8'd13, 8'd12, 8'd11, 8'd10, 4);
        drain();
        check(nreads - r0 == 8, "R9 back-to-back reads", nreads - r0, 8);

        // R5 R6: strobes inside fetch and send, memory rewritten after fetch
        r0 = nreads;
        start_burst(8'd40, 8'd40, 8'd41, 8'd200, 4);
        pulse_strobe();                       // lands in FETCH
        repeat (20) @(negedge clk);
        mem[40]  = ~mem[40];
        mem[41]  = 32'h0;
        mem[200] = 32'hFFFF_FFFF;
        pulse_strobe();                       // lands in SEND
        repeat (60) @(negedge clk);
        pulse_strobe();
        drain();
        check(nreads - r0 == 4, "R6 ignored strobe reads", nreads - r0, 4);

        // R7: disabled strobe ignored
        enable = 1'b0;
        r0 = nreads;
        pulse_strobe();
        repeat (40) @(negedge clk);
        check(nreads - r0 == 0, "R7 reads while disabled", nreads - r0, 0);
        check(rd_req === 1'b0, "R7 rd_req low", rd_req, 0);

        // R8: enable dropped during the second frame
        enable = 1'b1;
        r0 = nreads;
        start_burst(8'd5, 8'd6, 8'd7, 8'd8, 2);
        repeat (50) @(negedge clk);
        enable = 1'b0;
        drain();
        repeat (80) @(negedge clk);
        check(nreads - r0 == 4, "R8 reads before drop", nreads - r0, 4);
        enable = 1'b1;

        // after re-enable a normal burst resumes
        start_burst(8'd128, 8'd127, 8'd1, 8'd254, 4);
        drain();

        finished = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule